// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the scan timing for a parallel RGB LCD panel. Software programs the geometry through a small write port: the active size, the horizontal and vertical sync and porch lengths, and a control word. The control word holds a pixel-clock divider, an enable bit and one polarity-invert bit for each sync. The block divides the system clock down to a one-cycle pixel strobe. It then walks every line through four regions in a fixed order: sync, back porch, active and front porch. Each frame walks its lines through the same four regions.

The outputs are the HSYNC and VSYNC levels, a data-enable that marks visible pixels, and the column and row of the pixel on screen. A pixel fetch engine can use the coordinates to address memory. Two sticky status flags mark the start and the end of the visible part of each frame. Software clears a flag by writing a one to its bit.

Top module: `lcd_raster_timer`

## Requirements
- R1: A horizontal line is built, in order, from a sync region of (sync field + 1) pixels, a back porch of (back field + 3) pixels, an active region of 16 × (width field) pixels and a front porch of (front field + 1) pixels. Each pixel lasts one pixel period. The horizontal sync is asserted during exactly the sync pixels.
- R2: A frame is built, in order, from (vertical sync field) sync lines, (vertical back field) back-porch lines, (height field) active lines and (vertical front field) front-porch lines, with no bias on the vertical values. The vertical sync is asserted for every pixel of every sync line.
- R3: While the block is enabled, `pix_ce` is high for one cycle in every (divider + 1) cycles. The first pulse falls in cycle number `divider` after enabling, counting from 0. The scan position advances only on those cycles.
- R4: `de` is high only when the scan is inside both the horizontal and the vertical active regions.
- R5: `pix_x` is the index of the pixel within the horizontal active region, 0 at the first active pixel, and it is 0 outside that region. `pix_y` is the index of the line within the vertical active region, and it is 0 outside that region.
- R6: With control bit 9 clear, `hsync` is low while asserted and high otherwise. Setting bit 9 inverts it. Control bit 10 does the same for `vsync`.
- R7: Control bit 8 enables the block. While it is clear, the scan position is held at its start, `pix_ce` and `de` are low, both syncs sit at their inactive level and the coordinates are 0. After the bit is set, the scan begins with the first sync pixel of line 0.
- R8: Status bit 0 (begin of frame) is set once the first active pixel of active line 0 has been shown. It stays set until software clears it.
- R9: Status bit 1 (end of frame) is set once the last active pixel of the last active line has been shown. It stays set until software clears it.
- R10: A write to address 4 clears each status flag whose data bit is 1 and leaves alone each flag whose data bit is 0.
- R11: Register map. Address 0 holds the size: width/16 in bits 25:20 and height in bits 9:0. Addresses 1 (horizontal) and 2 (vertical) hold sync in bits 31:26, front porch in bits 15:8 and back porch in bits 7:0. Address 3 holds the control word: divider in bits 5:0, enable in bit 8, hsync invert in bit 9 and vsync invert in bit 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| pix_ce | output | 1 | Pixel-clock enable strobe |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable, high on visible pixels |
| pix_x | output | X_W | Column within the active region |
| pix_y | output | Y_W | Row within the active region |
| stat | output | 2 | Sticky flags: bit 0 begin of frame, bit 1 end of frame |

## Verification
A register write takes effect on the clock edge that samples it. When the control word turns on the enable, scan state 0 is visible in the next cycle. The bench counts cycles from that edge: pixel k of the scan is visible during cycles k·(d+1) through k·(d+1)+d, and `pix_ce` is high in the last of them. The status flags are registered, so a flag appears one cycle after the strobe of the pixel that sets it. A cleared flag reads as 0 in the cycle after its write. The driver pushes one expected item for every cycle in this numbering. Before it pushes anything, it arms the monitor on the same edge that enables the block. The monitor then compares one item on each falling edge.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_SIZE = 3'd0;
  localparam logic [ADDR_W-1:0] A_HORZ = 3'd1;
  localparam logic [ADDR_W-1:0] A_VERT = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  localparam int SYNC_F_W  = 6;
  localparam int PORCH_F_W = 8;
  localparam int WIDTH_F_W = 6;
  localparam int HEIGHT_F_W = 10;
  localparam int DIV_F_W   = 6;

  typedef struct packed {
    logic [SYNC_F_W-1:0]  sync;
    logic [PORCH_F_W-1:0] front;
    logic [PORCH_F_W-1:0] back;
  } span_t;

  typedef struct packed {
    logic               en;
    logic               inv_v;
    logic               inv_h;
    logic [DIV_F_W-1:0] div;
  } ctrl_t;
endpackage

// File: rtl/lcdt_pixdiv.sv
module lcdt_pixdiv #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             ce
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ce = en && (cnt_q >= div);
    if (!en || ce) cnt_d = '0;
    else           cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: two strobes in a row only when the divider is zero
  a_r3_ce_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> (!ce || div == '0 || !en));
endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis #(
  parameter int CNT_W = 12,
  parameter int OFF_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic [CNT_W-1:0] len_sync,
  input  logic [CNT_W-1:0] len_back,
  input  logic [CNT_W-1:0] len_act,
  input  logic [CNT_W-1:0] len_front,
  output logic             in_sync,
  output logic             in_act,
  output logic             last,
  output logic [OFF_W-1:0] offs
);
  localparam int SUM_W = CNT_W + 2;

  logic [CNT_W-1:0] pos_q, pos_d;
  logic [SUM_W-1:0] pos_x, act_start, act_end, total;

  always_comb begin
    pos_x     = SUM_W'(pos_q);
    act_start = SUM_W'(len_sync) + SUM_W'(len_back);
    act_end   = act_start + SUM_W'(len_act);
    total     = act_end + SUM_W'(len_front);
    in_sync   = pos_x < SUM_W'(len_sync);
    in_act    = (pos_x >= act_start) && (pos_x < act_end);
    last      = (total == '0) || (pos_x >= total - SUM_W'(1));
    offs      = in_act ? OFF_W'(pos_x - act_start) : '0;
    pos_d     = pos_q;
    if (!run)      pos_d = '0;
    else if (step) pos_d = last ? '0 : pos_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  // R1: the position returns to the start after the last one
  a_r1_wrap_to_start: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && last) |=> (pos_q == '0));
  // R3: no movement between strobes
  a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !step) |=> $stable(pos_q));
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcdt_pkg::*;
#(
  parameter int X_W    = 10,
  parameter int Y_W    = 10,
  parameter int HCNT_W = 12,
  parameter int VCNT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              pix_ce,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [X_W-1:0]    pix_x,
  output logic [Y_W-1:0]    pix_y,
  output logic [1:0]        stat
);
  localparam int ACT_PIX_W = WIDTH_F_W + 4;

  logic [1:0] rst_pipe;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  logic [WIDTH_F_W-1:0]  wdiv_q, wdiv_d;
  logic [HEIGHT_F_W-1:0] height_q, height_d;
  span_t                 horz_q, horz_d, vert_q, vert_d;
  ctrl_t                 ctrl_q, ctrl_d;
  logic [1:0]            stat_q, stat_d, clr;
  logic                  bof_hit, eof_hit;
  logic                  unused_bits;

  assign unused_bits = ^wr_data[19:16];

  always_comb begin
    wdiv_d   = wdiv_q;
    height_d = height_q;
    horz_d   = horz_q;
    vert_d   = vert_q;
    ctrl_d   = ctrl_q;
    clr      = '0;
    if (wr_en) begin
      case (wr_addr)
        A_SIZE: begin
          wdiv_d   = wr_data[25:20];
          height_d = wr_data[9:0];
        end
        A_HORZ: horz_d = '{sync: wr_data[31:26], front: wr_data[15:8], back: wr_data[7:0]};
        A_VERT: vert_d = '{sync: wr_data[31:26], front: wr_data[15:8], back: wr_data[7:0]};
        A_CTRL: ctrl_d = '{en: wr_data[8], inv_v: wr_data[10], inv_h: wr_data[9], div: wr_data[5:0]};
        A_STAT: clr    = wr_data[1:0];
        default: ;
      endcase
    end
    stat_d = (stat_q & ~clr) | {eof_hit, bof_hit};
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      wdiv_q   <= '0;
      height_q <= '0;
      horz_q   <= '0;
      vert_q   <= '0;
      ctrl_q   <= '0;
      stat_q   <= '0;
    end else begin
      wdiv_q   <= wdiv_d;
      height_q <= height_d;
      horz_q   <= horz_d;
      vert_q   <= vert_d;
      ctrl_q   <= ctrl_d;
      stat_q   <= stat_d;
    end
  end

  logic              h_sync, h_act, h_last, v_sync, v_act, v_last;
  logic [X_W-1:0]    h_off;
  logic [Y_W-1:0]    v_off;
  logic [HCNT_W-1:0] h_len_s, h_len_b, h_len_a, h_len_f;
  logic [VCNT_W-1:0] v_len_s, v_len_b, v_len_a, v_len_f;

  assign h_len_s = HCNT_W'(horz_q.sync)  + HCNT_W'(1);
  assign h_len_b = HCNT_W'(horz_q.back)  + HCNT_W'(3);
  assign h_len_a = HCNT_W'({wdiv_q, 4'b0000});
  assign h_len_f = HCNT_W'(horz_q.front) + HCNT_W'(1);
  assign v_len_s = VCNT_W'(vert_q.sync);
  assign v_len_b = VCNT_W'(vert_q.back);
  assign v_len_a = VCNT_W'(height_q);
  assign v_len_f = VCNT_W'(vert_q.front);

  lcdt_pixdiv #(.DIV_W(DIV_F_W)) u_div (
    .clk(clk), .rst_n(rst_int), .en(ctrl_q.en), .div(ctrl_q.div), .ce(pix_ce)
  );

  lcdt_axis #(.CNT_W(HCNT_W), .OFF_W(X_W)) u_h (
    .clk(clk), .rst_n(rst_int), .run(ctrl_q.en), .step(pix_ce),
    .len_sync(h_len_s), .len_back(h_len_b), .len_act(h_len_a), .len_front(h_len_f),
    .in_sync(h_sync), .in_act(h_act), .last(h_last), .offs(h_off)
  );

  lcdt_axis #(.CNT_W(VCNT_W), .OFF_W(Y_W)) u_v (
    .clk(clk), .rst_n(rst_int), .run(ctrl_q.en), .step(pix_ce && h_last),
    .len_sync(v_len_s), .len_back(v_len_b), .len_act(v_len_a), .len_front(v_len_f),
    .in_sync(v_sync), .in_act(v_act), .last(v_last), .offs(v_off)
  );

  logic unused_vlast;
  assign unused_vlast = v_last;

  always_comb begin
    de      = ctrl_q.en & h_act & v_act;
    hsync   = (ctrl_q.en & h_sync) ^ ~ctrl_q.inv_h;
    vsync   = (ctrl_q.en & v_sync) ^ ~ctrl_q.inv_v;
    pix_x   = ctrl_q.en ? h_off : '0;
    pix_y   = ctrl_q.en ? v_off : '0;
    bof_hit = pix_ce && de && (pix_x == '0) && (pix_y == '0);
    eof_hit = pix_ce && de
              && (pix_x == X_W'({wdiv_q, 4'b0000}) - X_W'(1))
              && (pix_y == Y_W'(height_q) - Y_W'(1));
    stat    = stat_q;
  end

  // R5: the column stays inside the programmed width
  a_r5_x_in_width: assert property (@(posedge clk) disable iff (!rst_int)
    de |-> (int'(pix_x) < int'({wdiv_q, 4'b0000})));
  // R7: no pixel strobe while disabled
  a_r7_idle_no_ce: assert property (@(posedge clk) disable iff (!rst_int)
    !ctrl_q.en |-> !pix_ce);
  // R8: begin-of-frame stays until cleared
  a_r8_bof_sticky: assert property (@(posedge clk) disable iff (!rst_int)
    (stat[0] && !(wr_en && wr_addr == A_STAT && wr_data[0])) |=> stat[0]);
  // R9: end-of-frame stays until cleared
  a_r9_eof_sticky: assert property (@(posedge clk) disable iff (!rst_int)
    (stat[1] && !(wr_en && wr_addr == A_STAT && wr_data[1])) |=> stat[1]);
endmodule

// File: tb/lcd_raster_timer_tb.sv
module lcd_raster_timer_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        pix_ce, hsync, vsync, de;
  logic [9:0]  pix_x, pix_y;
  logic [1:0]  stat;

  always #(CLK_P/2) clk = ~clk;

  lcd_raster_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .stat(stat)
  );

  typedef struct packed {
    logic       hs;
    logic       vs;
    logic       de;
    logic       ce;
    logic [9:0] x;
    logic [9:0] y;
    logic [1:0] st;
  } exp_t;

  exp_t q[$];
  bit   mon_on = 1'b0;
  bit   done = 1'b0;
  int   n_chk = 0;
  int   n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input bit start);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    if (start) mon_on = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: one expected item per cycle, counted from the enabling edge
  task automatic push_frames(input int hsf, input int hbf, input int wf, input int hff,
                             input int vs, input int vb, input int va, input int vf,
                             input int d, input bit inv_h, input bit inv_v, input int nfr);
    int hs = hsf + 1;
    int hb = hbf + 3;
    int ha = 16 * wf;
    int hf = hff + 1;
    int ht = hs + hb + ha + hf;
    int vt = vs + vb + va + vf;
    int i0 = (vs + vb) * ht + hs + hb;
    int il = (vs + vb + va - 1) * ht + hs + hb + ha - 1;
    for (int f = 0; f < nfr; f++)
      for (int l = 0; l < vt; l++)
        for (int p = 0; p < ht; p++)
          for (int r = 0; r <= d; r++) begin
            exp_t e;
            int idx = (f * vt + l) * ht + p;
            int c = idx * (d + 1) + r;
            bit hsa = (p < hs);
            bit vsa = (l < vs);
            bit hact = (p >= hs + hb) && (p < hs + hb + ha);
            bit vact = (l >= vs + vb) && (l < vs + vb + va);
            e.hs = inv_h ? hsa : !hsa;
            e.vs = inv_v ? vsa : !vsa;
            e.de = hact && vact;
            e.ce = (r == d);
            e.x  = hact ? 10'(p - hs - hb) : 10'd0;
            e.y  = vact ? 10'(l - vs - vb) : 10'd0;
            e.st = {c >= (il + 1) * (d + 1), c >= (i0 + 1) * (d + 1)};
            q.push_back(e);
          end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (mon_on && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(hsync === e.hs, "R1,R6 hsync", hsync, e.hs);
      chk(vsync === e.vs, "R2,R6 vsync", vsync, e.vs);
      chk(de === e.de, "R4 de", de, e.de);
      chk(pix_ce === e.ce, "R3 pix_ce", pix_ce, e.ce);
      chk(pix_x === e.x, "R5 pix_x", pix_x, e.x);
      chk(pix_y === e.y, "R5 pix_y", pix_y, e.y);
      chk(stat[0] === e.st[0], "R8 bof", stat[0], e.st[0]);
      chk(stat[1] === e.st[1], "R9 eof", stat[1], e.st[1]);
    end
  end

  task automatic chk_idle(input string req);
    chk(hsync === 1'b1 && vsync === 1'b1, req, {hsync, vsync}, 2'b11);
    chk(de === 1'b0 && pix_ce === 1'b0, req, {de, pix_ce}, 2'b00);
    chk(pix_x === '0 && pix_y === '0, req, {pix_x, pix_y}, 0);
  endtask

  task automatic run_and_drain();
    wait (q.size() == 0);
    @(negedge clk);
    mon_on = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R7 reset");
    chk(stat === 2'b00, "R8,R9 reset flags", stat, 0);

    // Pattern 1 (R11 map): 16 wide, 3 high, divider 0, normal polarity
    wr(3'd0, (32'd1 << 20) | 32'd3, 1'b0);
    wr(3'd1, (32'd1 << 26) | (32'd1 << 8) | 32'd0, 1'b0);
    wr(3'd2, (32'd1 << 26) | (32'd1 << 8) | 32'd2, 1'b0);
    push_frames(1, 0, 1, 1, 1, 2, 3, 1, 0, 1'b0, 1'b0, 2);
    wr(3'd3, 32'h100, 1'b1);
    run_and_drain();

    // R7: disabling parks everything
    wr(3'd3, 32'h000, 1'b0);
    chk_idle("R7 disabled");
    chk(stat === 2'b11, "R8,R9 sticky after frames", stat, 3);
    repeat (5) @(negedge clk);
    chk_idle("R7 held");
    chk(stat === 2'b11, "R8,R9 sticky while idle", stat, 3);

    // R10: write-one-to-clear
    wr(3'd4, 32'h1, 1'b0);
    chk(stat === 2'b10, "R10 clear bof only", stat, 2);
    wr(3'd4, 32'h0, 1'b0);
    chk(stat === 2'b10, "R10 zero write no effect", stat, 2);
    wr(3'd4, 32'h2, 1'b0);
    chk(stat === 2'b00, "R10 clear eof", stat, 0);

    // Pattern 2: 32 wide, 2 high, divider 2, both syncs inverted, restart (R7)
    wr(3'd0, (32'd2 << 20) | 32'd2, 1'b0);
    wr(3'd1, (32'd0 << 26) | (32'd0 << 8) | 32'd2, 1'b0);
    wr(3'd2, (32'd2 << 26) | (32'd2 << 8) | 32'd0, 1'b0);
    push_frames(0, 2, 2, 0, 2, 0, 2, 2, 2, 1'b1, 1'b1, 2);
    wr(3'd3, 32'h702, 1'b1);
    run_and_drain();

    wr(3'd3, 32'h600, 1'b0);
    chk(hsync === 1'b0 && vsync === 1'b0, "R6,R7 inverted idle level", {hsync, vsync}, 0);
    chk(de === 1'b0 && pix_ce === 1'b0, "R7 inverted idle", {de, pix_ce}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R3 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule